// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a synchronous valid/ready request bus and an external 128K x 8 asynchronous static RAM. It accepts one read or write request at a time. Each request becomes a sequence of clock-counted phases on the memory pins: a 17-bit address, an active-low enable, an active-high enable, an output enable, a read/write strobe, and a data bus that is split into an outgoing byte, an incoming byte and a driver enable. Every phase length comes from a nanosecond minimum that is divided by the clock period and rounded up, with at least one cycle per phase. A parameter chooses between the faster and the slower speed grade.

For a read, the selected memory drives the bus for the whole access time. The controller samples the byte on the last cycle of that phase and returns it with a single-cycle valid pulse. For a write, the strobe goes low first. The controller waits out the interval in which the memory may still be driving the bus, and only then enables its own drivers. It then holds the byte for the data-setup window. The address changes only on a clock edge at which both enables were inactive.

A sleep pulse deselects the memory so that its supply can be lowered for data retention. A wake pulse starts a recovery lockout of about 5 ms, and no new access is accepted until the lockout has expired.

Top module: `asram_sequencer`

## Requirements
- R1: While reset is held and on the first cycle after it, req_ready is 1, mem_ce_n is 1, mem_ce is 0, mem_oe_n is 1, mem_we_n is 1, mem_dq_oe is 0 and rsp_valid is 0.
- R2: An accepted read (req_write = 0) holds mem_ce_n = 0, mem_ce = 1, mem_oe_n = 0, mem_we_n = 1 and mem_dq_oe = 0 for exactly RD cycles. RD is the larger of ceil(tACC / clock) and ceil(tRC / clock): 4 cycles at the default 20 ns clock and the faster grade.
- R3: A read samples mem_dq_in on its last access cycle. rsp_valid is 1 for exactly the one cycle after the access, and rsp_rdata then carries the byte that was sampled.
- R4: An accepted write (req_write = 1) holds both enables asserted, mem_we_n = 0 and mem_oe_n = 1 for TURN + DATA cycles. This is 4 cycles by default, which covers the write pulse, the select-to-end and the write-cycle minimums.
- R5: During a write, mem_dq_oe stays 0 for the first TURN cycles, where TURN = ceil(25 ns / clock) = 2. mem_dq_oe is never 1 while mem_oe_n = 0 or mem_we_n = 1.
- R6: mem_dq_out equals the request's byte for the last DATA cycles of a write, with DATA = 2 by default. mem_dq_oe and mem_we_n both return high on the same edge.
- R7: req_ready is 1 only when the sequencer is idle, and it is 0 during every access cycle. While req_ready is 1, the memory is deselected and not driven.
- R8: mem_addr holds the accepted address through the whole access. It changes only on an edge where mem_ce_n was 1 in the previous cycle.
- R9: A sleep_req pulse in idle sets mem_ce_n = 1, mem_ce = 0 and req_ready = 0 from the next cycle. Requests presented while asleep cause no strobe, and memory contents are unchanged afterwards.
- R10: After a wake_req pulse during sleep, req_ready stays 0 for exactly REC = ceil(RECOVER_NS / clock) cycles (100 in the bench), then returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken on this edge when valid is also 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse marking read data |
| rsp_rdata | output | 8 | Byte returned by a read |
| sleep_req | input | 1 | Enter retention (taken in idle only) |
| wake_req | input | 1 | Leave retention (taken in sleep only) |
| mem_addr | output | 17 | Address to memory |
| mem_ce_n | output | 1 | Active-low chip enable |
| mem_ce | output | 1 | Active-high chip enable |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Read/write strobe, low = write |
| mem_dq_out | output | 8 | Byte driven onto the data bus |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_in | input | 8 | Byte read from the data bus |

## Verification
Cycles are counted from the accepting edge, and cycle k is the interval after the k-th edge. The strobes of a read are due in cycles 1 to RD, its response in cycle RD+1, and the response must be gone in cycle RD+2. The strobes of a write are due in cycles 1 to TURN+DATA, with the drivers enabled only from cycle TURN+1, and idle returns in cycle TURN+DATA+1. After a wake pulse, ready must stay low through cycle REC and rise in cycle REC+1. The bench drives inputs and samples outputs on falling edges, and it walks these cycle numbers one by one. Each value is therefore checked in the exact cycle it is due, and not just at some point.

// File: rtl/asram_pkg.sv
// Package: shared state type and the helpers that turn nanosecond minimums
// into clock-cycle counts. Assumes positive clock periods in nanoseconds.
package asram_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_READ,
        SEQ_WTURN,
        SEQ_WDATA,
        SEQ_SLEEP,
        SEQ_WAKE
    } seq_state_t;

    // Larger of two integers.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Ceiling of ns / clk_ns, never below one cycle.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return imax(1, c);
    endfunction

endpackage

// File: rtl/asram_phase_timer.sv
// Phase timer: loaded with (length - 1) on the edge that enters a phase,
// counts down once per cycle, and reports done in the phase's last cycle.
// Assumes a load never arrives while a phase that must finish is running.
module asram_phase_timer #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] remain;

    // Load on phase entry, otherwise count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n)                 remain <= '0;
        else if (load)              remain <= load_val;
        else if (remain != '0)      remain <= remain - 1'b1;
    end

    assign done = (remain == '0);
endmodule

// File: rtl/asram_wake_guard.sv
// Recovery lockout counter: started by a wake, it reports done in the last
// cycle of a CYCLES-long window. The count may be large (millisecond range).
module asram_wake_guard #(
    parameter int CYCLES = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int W = $clog2(CYCLES + 1);
    localparam logic [W-1:0] LOAD = W'(CYCLES - 1);

    logic [W-1:0] left;

    // Load the window on wake, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            left <= '0;
        else if (start)        left <= LOAD;
        else if (left != '0)   left <= left - 1'b1;
    end

    assign done = (left == '0);
endmodule

// File: rtl/asram_dq_path.sv
// Data path: holds the write byte, registers the driver enable from the
// next sequencer state (glitch-free pin), captures the read byte and
// produces the one-cycle response pulse.
module asram_dq_path #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_wdata,
    input  logic [DW-1:0] wdata,
    input  logic          drive_nxt,
    input  logic          capture,
    input  logic [DW-1:0] dq_in,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);
    // Register write byte, driver enable, read byte and response pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_out <= '0;
            dq_oe  <= 1'b0;
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            if (load_wdata) dq_out <= wdata;
            dq_oe  <= drive_nxt;
            rvalid <= capture;
            if (capture)    rdata <= dq_in;
        end
    end
endmodule

// File: rtl/asram_sequencer.sv
// Asynchronous SRAM sequencer: one request at a time from a valid/ready bus,
// played out as clock-counted phases on the memory pins. Strobes are
// registered from the next state so the pins never glitch. Assumes the
// memory's minimum times for the chosen grade; SLOW_GRADE = 1 selects the
// slower part. Requests win over sleep in the same idle cycle.
module asram_sequencer
    import asram_pkg::*;
#(
    parameter int AW            = 17,
    parameter int DW            = 8,
    parameter int CLK_PERIOD_NS = 20,
    parameter bit SLOW_GRADE    = 1'b0,
    parameter int RECOVER_NS    = 5000000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    input  logic          sleep_req,
    input  logic          wake_req,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce_n,
    output logic          mem_ce,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in
);
    // Grade minimums in ns.
    localparam int T_ACC = SLOW_GRADE ? 85 : 70;
    localparam int T_RC  = SLOW_GRADE ? 85 : 70;
    localparam int T_WC  = SLOW_GRADE ? 85 : 70;
    localparam int T_WP  = SLOW_GRADE ? 60 : 50;
    localparam int T_CW  = SLOW_GRADE ? 75 : 60;
    localparam int T_DS  = SLOW_GRADE ? 35 : 30;
    localparam int T_WHZ = SLOW_GRADE ? 30 : 25;

    // Phase lengths in cycles.
    localparam int RD_CYC   = imax(ns_to_cyc(T_ACC, CLK_PERIOD_NS),
                                   ns_to_cyc(T_RC, CLK_PERIOD_NS));
    localparam int TURN_CYC = ns_to_cyc(T_WHZ, CLK_PERIOD_NS);
    localparam int DATA_CYC = imax(imax(ns_to_cyc(T_DS, CLK_PERIOD_NS),
                                        ns_to_cyc(T_WP, CLK_PERIOD_NS) - TURN_CYC),
                                   imax(imax(ns_to_cyc(T_CW, CLK_PERIOD_NS) - TURN_CYC,
                                             ns_to_cyc(T_WC, CLK_PERIOD_NS) - TURN_CYC),
                                        1));
    localparam int REC_CYC  = ns_to_cyc(RECOVER_NS, CLK_PERIOD_NS);
    localparam int MAX_CYC  = imax(RD_CYC, imax(TURN_CYC, DATA_CYC));
    localparam int TW       = $clog2(MAX_CYC + 1);

    localparam logic [TW-1:0] RD_LD   = TW'(RD_CYC - 1);
    localparam logic [TW-1:0] TURN_LD = TW'(TURN_CYC - 1);
    localparam logic [TW-1:0] DATA_LD = TW'(DATA_CYC - 1);

    seq_state_t    state, state_nxt;
    logic          accept;
    logic          t_load, t_done;
    logic [TW-1:0] t_val;
    logic          g_start, g_done;
    logic          capture;
    logic          sel_nxt;

    assign req_ready = (state == SEQ_IDLE);
    assign accept    = req_valid && req_ready;

    // Next-state and phase-timer load decisions.
    always_comb begin
        state_nxt = state;
        t_load    = 1'b0;
        t_val     = '0;
        g_start   = 1'b0;
        capture   = 1'b0;
        case (state)
            SEQ_IDLE: begin
                if (accept) begin
                    t_load = 1'b1;
                    if (req_write) begin
                        state_nxt = SEQ_WTURN;
                        t_val     = TURN_LD;
                    end else begin
                        state_nxt = SEQ_READ;
                        t_val     = RD_LD;
                    end
                end else if (sleep_req) begin
                    state_nxt = SEQ_SLEEP;
                end
            end
            SEQ_READ: begin
                if (t_done) begin
                    capture   = 1'b1;
                    state_nxt = SEQ_IDLE;
                end
            end
            SEQ_WTURN: begin
                if (t_done) begin
                    state_nxt = SEQ_WDATA;
                    t_load    = 1'b1;
                    t_val     = DATA_LD;
                end
            end
            SEQ_WDATA: begin
                if (t_done) state_nxt = SEQ_IDLE;
            end
            SEQ_SLEEP: begin
                if (wake_req) begin
                    state_nxt = SEQ_WAKE;
                    g_start   = 1'b1;
                end
            end
            SEQ_WAKE: begin
                if (g_done) state_nxt = SEQ_IDLE;
            end
            default: state_nxt = SEQ_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEQ_IDLE;
        else        state <= state_nxt;
    end

    assign sel_nxt = (state_nxt == SEQ_READ) || (state_nxt == SEQ_WTURN) ||
                     (state_nxt == SEQ_WDATA);

    // Registered memory strobes and address, decoded from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_ce_n <= 1'b1;
            mem_ce   <= 1'b0;
            mem_oe_n <= 1'b1;
            mem_we_n <= 1'b1;
            mem_addr <= '0;
        end else begin
            mem_ce_n <= !sel_nxt;
            mem_ce   <= sel_nxt;
            mem_oe_n <= (state_nxt != SEQ_READ);
            mem_we_n <= !((state_nxt == SEQ_WTURN) || (state_nxt == SEQ_WDATA));
            if (accept) mem_addr <= req_addr;
        end
    end

    asram_phase_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    asram_wake_guard #(.CYCLES(REC_CYC)) u_guard (
        .clk   (clk),
        .rst_n (rst_n),
        .start (g_start),
        .done  (g_done)
    );

    asram_dq_path #(.DW(DW)) u_dq (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_wdata (accept && req_write),
        .wdata      (req_wdata),
        .drive_nxt  (state_nxt == SEQ_WDATA),
        .capture    (capture),
        .dq_in      (mem_dq_in),
        .dq_out     (mem_dq_out),
        .dq_oe      (mem_dq_oe),
        .rdata      (rsp_rdata),
        .rvalid     (rsp_valid)
    );
endmodule

// File: rtl/asram_sequencer_chk.sv
// Checker for asram_sequencer: pin-level protocol properties, bound below.
// Assumes TURN_CYC matches the sequencer's bus-turnaround phase.
module asram_sequencer_chk #(
    parameter int AW       = 17,
    parameter int TURN_CYC = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ce_n,
    input logic          mem_ce,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic          mem_dq_oe
);
    int we_low_run;

    // Count consecutive cycles with the write strobe low.
    always_ff @(posedge clk) begin
        if (!rst_n)          we_low_run <= 0;
        else if (!mem_we_n)  we_low_run <= (we_low_run < 1000) ? we_low_run + 1 : we_low_run;
        else                 we_low_run <= 0;
    end

    // R5
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n && mem_oe_n));

    // R5
    turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (we_low_run >= TURN_CYC));

    // R4
    write_oe_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && !mem_ce_n && mem_ce));

    // R8
    addr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mem_addr) |-> $past(mem_ce_n));

    // R3
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R7
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && !mem_ce && mem_we_n && !mem_dq_oe));
endmodule

bind asram_sequencer asram_sequencer_chk #(
    .AW       (AW),
    .TURN_CYC (TURN_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_ce    (mem_ce),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/asram_sequencer_test.sv
// Bench: vector table of writes and reads, then directed reset and
// sleep/wake tests. Holds a behavioural memory model of its own.
module asram_sequencer_test;
    localparam int RD   = 4;
    localparam int TURN = 2;
    localparam int DATA = 2;
    localparam int REC  = 100;

    typedef struct packed {
        logic        wr;
        logic [16:0] addr;
        logic [7:0]  data;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 17'h00000, 8'hA5},
        '{1'b1, 17'h1FFFF, 8'h3C},
        '{1'b1, 17'h0ABCD, 8'hFF},
        '{1'b1, 17'h00005, 8'h11},
        '{1'b0, 17'h1FFFF, 8'h3C},
        '{1'b0, 17'h00000, 8'hA5},
        '{1'b1, 17'h00000, 8'h00},
        '{1'b0, 17'h00000, 8'h00},
        '{1'b0, 17'h0ABCD, 8'hFF},
        '{1'b0, 17'h00777, 8'h00}
    };

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        sleep_req = 1'b0, wake_req = 1'b0;
    logic        req_ready, rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [16:0] mem_addr;
    logic        mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = '0;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 1'b0;
    logic [7:0] model [int];

    asram_sequencer #(.RECOVER_NS(2000)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .sleep_req(sleep_req), .wake_req(wake_req),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_ce(mem_ce),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    // Memory model: store on edges where a driven write is in progress.
    always @(posedge clk)
        if (!mem_ce_n && mem_ce && !mem_we_n && mem_dq_oe)
            model[int'(mem_addr)] = mem_dq_out;

    // Memory model: drive read data while selected with outputs enabled.
    always @(negedge clk)
        mem_dq_in <= (!mem_ce_n && mem_ce && !mem_oe_n && mem_we_n &&
                      model.exists(int'(mem_addr))) ? model[int'(mem_addr)] : 8'h00;

    // R5: no driver enable while the memory may be driving.
    always @(negedge clk)
        if (rst_n && mem_dq_oe)
            chk(!mem_we_n && mem_oe_n, "R5", "drive during memory output",
                {mem_we_n, mem_oe_n}, 2'b01);

    task automatic present(input bit wr, input logic [16:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_write(input logic [16:0] a, input logic [7:0] d);
        present(1'b1, a, d);
        for (int j = 1; j <= TURN + DATA; j++) begin
            chk(mem_we_n == 1'b0, "R4", "we_n during write", mem_we_n, 0);
            chk(mem_oe_n == 1'b1, "R4", "oe_n during write", mem_oe_n, 1);
            chk(!mem_ce_n && mem_ce, "R4", "enables during write", {mem_ce_n, mem_ce}, 2'b01);
            chk(mem_dq_oe == (j > TURN), "R5", "dq_oe phase", mem_dq_oe, int'(j > TURN));
            if (j > TURN) chk(mem_dq_out == d, "R6", "write byte", mem_dq_out, d);
            chk(mem_addr == a, "R8", "address held", mem_addr, a);
            chk(req_ready == 1'b0, "R7", "ready while busy", req_ready, 0);
            @(negedge clk);
        end
        chk(mem_we_n && !mem_dq_oe, "R6", "strobe and driver end together",
            {mem_we_n, mem_dq_oe}, 2'b10);
        chk(req_ready == 1'b1, "R7", "ready after write", req_ready, 1);
    endtask

    task automatic do_read(input logic [16:0] a, input logic [7:0] exp);
        present(1'b0, a, 8'h00);
        for (int j = 1; j <= RD; j++) begin
            chk(!mem_ce_n && mem_ce, "R2", "enables during read", {mem_ce_n, mem_ce}, 2'b01);
            chk(mem_oe_n == 1'b0 && mem_we_n == 1'b1, "R2", "oe/we during read",
                {mem_oe_n, mem_we_n}, 2'b01);
            chk(mem_dq_oe == 1'b0, "R2", "no drive during read", mem_dq_oe, 0);
            chk(mem_addr == a, "R8", "address held", mem_addr, a);
            chk(req_ready == 1'b0, "R7", "ready while busy", req_ready, 0);
            chk(rsp_valid == 1'b0, "R3", "early response", rsp_valid, 0);
            @(negedge clk);
        end
        chk(mem_ce_n == 1'b1, "R2", "deselect after RD cycles", mem_ce_n, 1);
        chk(rsp_valid == 1'b1, "R3", "response pulse", rsp_valid, 1);
        chk(rsp_rdata == exp, "R3", "read byte", rsp_rdata, exp);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R3", "pulse one cycle", rsp_valid, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog run did not complete actual=0 expected=1");
        finish_run();
    end

    initial begin
        // R1: reset state.
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
        chk(mem_ce_n && !mem_ce && mem_oe_n && mem_we_n, "R1", "strobes in reset",
            {mem_ce_n, mem_ce, mem_oe_n, mem_we_n}, 4'b1011);
        chk(!mem_dq_oe && !rsp_valid, "R1", "drive/response in reset",
            {mem_dq_oe, rsp_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && mem_ce_n && !mem_ce && mem_we_n && !mem_dq_oe, "R1",
            "first cycle after reset", {req_ready, mem_ce_n, mem_ce, mem_we_n, mem_dq_oe},
            5'b11010);

        // Table walk.
        for (int v = 0; v < NV; v++) begin
            if (VECS[v].wr) do_write(VECS[v].addr, VECS[v].data);
            else            do_read(VECS[v].addr, VECS[v].data);
        end

        // R9: sleep entry.
        @(negedge clk);
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        chk(mem_ce_n && !mem_ce, "R9", "deselect in sleep", {mem_ce_n, mem_ce}, 2'b10);
        chk(req_ready == 1'b0, "R9", "ready in sleep", req_ready, 0);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00005; req_wdata = 8'h77;
        for (int j = 0; j < 5; j++) begin
            @(negedge clk);
            chk(mem_we_n && mem_ce_n, "R9", "request ignored asleep",
                {mem_we_n, mem_ce_n}, 2'b11);
        end
        req_valid = 1'b0;

        // R10: wake and recovery lockout.
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        for (int j = 1; j <= REC; j++) begin
            chk(req_ready == 1'b0, "R10", "ready during recovery", req_ready, 0);
            @(negedge clk);
        end
        chk(req_ready == 1'b1, "R10", "ready after recovery", req_ready, 1);

        // R9: memory unchanged by the ignored request.
        do_read(17'h00005, 8'h11);

        finish_run();
    end
endmodule